// File: doc/BRIEF.md
# CAS-before-RAS Refresh Generator

This block keeps a dynamic memory's contents alive by issuing refresh cycles in which the column strobe falls before the row strobe, so the memory uses its own internal row counter and no address needs to be driven. An interval timer produces one refresh obligation per interval (by default 15.6 µs, which spreads 4096 refreshes across a 64 ms retention window). Obligations collect in a pending counter; while it is non-zero the block asks the access controller for the bus, and when the controller grants it the block runs one complete refresh cycle on its own strobe outputs.

A few obligations may be postponed, for example while the controller finishes a page burst. Once the pending count reaches an urgency limit the block raises a separate urgent flag, telling the controller that refresh must now take priority. The pending count saturates at a maximum depth.

The sequencer has five states. `ST_IDLE` holds all strobes high and leaves on a grant while work is pending. `ST_SETUP` keeps both strobes high for one cycle so the row strobe is high before the column strobe falls. `ST_LEAD` drops the column strobe alone for the lead time. `ST_ACTIVE` drops the row strobe too for the minimum row-active time. `ST_RECOVER` raises both strobes for the precharge time, after which the sequencer returns to `ST_IDLE`. Write enable and output enable are never asserted. The cycle counts come from nanosecond parameters divided by the clock period, rounded up; the recovery phase is stretched if the full cycle would be shorter than the minimum cycle time.

Top module: `cbr_refresh_gen`

## Requirements
- R1: During and right after reset, ras_n, cas_n, we_n and oe_n are 1 and busy, ref_req and ref_urgent are 0.
- R2: The first pending obligation appears exactly TICK cycles (INTERVAL_NS/CLK_NS) after reset release, and one further obligation is added every TICK cycles; ref_req is 1 whenever the pending count is non-zero.
- R3: A grant sampled with ref_req high starts a cycle seen on the next cycles as: one cycle with both strobes high, then LEAD cycles with cas_n=0 and ras_n=1, then ACT cycles with both low, then REC cycles with both high; with 10 ns clock defaults this is 1, 1, 6 and 4 cycles.
- R4: we_n and oe_n stay 1 in every cycle, including every refresh phase.
- R5: ref_urgent is 1 exactly while the pending count is at least URGENT_LIMIT; with the bench settings (limit 3, tick 64) it first rises 192 cycles after reset release.
- R6: The pending count saturates at MAX_PEND: after more intervals than MAX_PEND with no grant, exactly MAX_PEND back-to-back refreshes are performed before ref_req drops.
- R7: A grant while nothing is pending leaves busy 0 and all strobes high; a grant held high during a refresh does not shorten or restart it.
- R8: busy is 1 exactly in the 12 (default) cycles of a refresh and 0 in the idle cycle between two back-to-back refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | At least one refresh is pending |
| ref_urgent | output | 1 | Pending count has reached the urgency limit |
| busy | output | 1 | A refresh cycle is on the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| oe_n | output | 1 | Output enable, active low, held high |

## Verification
A pending obligation becomes visible on ref_req on the same edge that closes an interval, so the first request is due exactly TICK edges after reset release and the urgent flag three intervals later; the bench keeps its own edge counter from reset release and samples those flags on the falling edge where the count reaches the due value and on the one before. A grant raised at a falling edge is taken at the next rising edge and the setup phase appears one cycle later, so the driver pushes one expected strobe pattern per cycle starting with the current idle cycle, and the monitor pops one item at every falling edge. The last refresh of a saturated backlog must end with ref_req low before the next interval closes, which the bench checks once the queue drains.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LEAD,
        ST_ACTIVE,
        ST_RECOVER
    } cbr_state_e;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
    parameter int unsigned TICK_CYCLES = 1560
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cbr_backlog.sv
module cbr_backlog #(
    parameter int unsigned MAX_PEND     = 8,
    parameter int unsigned URGENT_LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic take_i,
    output logic req_o,
    output logic urgent_o
);
    localparam int unsigned PW = $clog2(MAX_PEND + 1);
    localparam logic [PW-1:0] PMAX = PW'(MAX_PEND);
    localparam logic [PW-1:0] PURG = PW'(URGENT_LIMIT);

    logic [PW-1:0] pend_q;
    logic          inc, dec;

    assign inc      = tick_i && (pend_q != PMAX);
    assign dec      = take_i && (pend_q != '0);
    assign req_o    = (pend_q != '0);
    assign urgent_o = (pend_q >= PURG);

    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else if (inc && !dec)
            pend_q <= pend_q + 1'b1;
        else if (dec && !inc)
            pend_q <= pend_q - 1'b1;
    end

    // R6
    pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PMAX);

    // R5
    urgent_implies_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        urgent_o |-> req_o);
endmodule

// File: rtl/cbr_sequencer.sv
module cbr_sequencer
    import cbr_pkg::*;
#(
    parameter int unsigned CLK_NS       = 10,
    parameter int unsigned LEAD_NS      = 10,
    parameter int unsigned ACTIVE_NS    = 60,
    parameter int unsigned PRECHARGE_NS = 40,
    parameter int unsigned CYCLE_NS     = 110
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic gnt_i,
    output logic take_o,
    output logic busy_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o,
    output logic oe_n_o
);
    localparam int unsigned LEAD_C = ns_to_cyc(LEAD_NS, CLK_NS);
    localparam int unsigned ACT_C  = ns_to_cyc(ACTIVE_NS, CLK_NS);
    localparam int unsigned PRE_C  = ns_to_cyc(PRECHARGE_NS, CLK_NS);
    localparam int unsigned TOT_C  = ns_to_cyc(CYCLE_NS, CLK_NS);
    localparam int unsigned FIX_C  = LEAD_C + ACT_C + 1;
    localparam int unsigned REC_C  = (TOT_C > FIX_C + PRE_C) ? (TOT_C - FIX_C) : PRE_C;
    localparam int unsigned MAX_C  = (ACT_C > REC_C) ? ((ACT_C > LEAD_C) ? ACT_C : LEAD_C)
                                                     : ((REC_C > LEAD_C) ? REC_C : LEAD_C);
    localparam int unsigned PW     = $clog2(MAX_C + 1);

    cbr_state_e    state_q, state_nx;
    logic [PW-1:0] phase_q;
    logic          phase_done;

    assign phase_done = (phase_q == '0);
    assign take_o     = (state_q == ST_IDLE) && req_i && gnt_i;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_i && gnt_i) state_nx = ST_SETUP;
            ST_SETUP:   state_nx = ST_LEAD;
            ST_LEAD:    if (phase_done) state_nx = ST_ACTIVE;
            ST_ACTIVE:  if (phase_done) state_nx = ST_RECOVER;
            ST_RECOVER: if (phase_done) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
        end else begin
            state_q <= state_nx;
            if (state_nx != state_q) begin
                unique case (state_nx)
                    ST_LEAD:    phase_q <= PW'(LEAD_C - 1);
                    ST_ACTIVE:  phase_q <= PW'(ACT_C - 1);
                    ST_RECOVER: phase_q <= PW'(REC_C - 1);
                    default:    phase_q <= '0;
                endcase
            end else if (!phase_done) begin
                phase_q <= phase_q - 1'b1;
            end
        end
    end

    always_comb begin
        busy_o  = 1'b1;
        ras_n_o = 1'b1;
        cas_n_o = 1'b1;
        we_n_o  = 1'b1;
        oe_n_o  = 1'b1;
        unique case (state_q)
            ST_IDLE:    busy_o = 1'b0;
            ST_SETUP:   ;
            ST_LEAD:    cas_n_o = 1'b0;
            ST_ACTIVE:  begin
                cas_n_o = 1'b0;
                ras_n_o = 1'b0;
            end
            ST_RECOVER: ;
            default:    busy_o = 1'b0;
        endcase
    end

    // R3
    cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> $past(!cas_n_o));

    // R3
    ras_high_at_cas_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n_o) |-> ras_n_o);

    // R7
    no_start_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !req_i) |=> !busy_o);

    // R8
    strobe_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o || !cas_n_o) |-> busy_o);
endmodule

// File: rtl/cbr_refresh_gen.sv
module cbr_refresh_gen #(
    parameter int unsigned CLK_NS       = 10,
    parameter int unsigned INTERVAL_NS  = 15600,
    parameter int unsigned MAX_PEND     = 8,
    parameter int unsigned URGENT_LIMIT = 6,
    parameter int unsigned LEAD_NS      = 10,
    parameter int unsigned ACTIVE_NS    = 60,
    parameter int unsigned PRECHARGE_NS = 40,
    parameter int unsigned CYCLE_NS     = 110
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ref_urgent,
    output logic busy,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic oe_n
);
    localparam int unsigned TICK_CYCLES = INTERVAL_NS / CLK_NS;

    logic tick;
    logic take;

    cbr_interval_timer #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    cbr_backlog #(
        .MAX_PEND     (MAX_PEND),
        .URGENT_LIMIT (URGENT_LIMIT)
    ) u_backlog (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .take_i   (take),
        .req_o    (ref_req),
        .urgent_o (ref_urgent)
    );

    cbr_sequencer #(
        .CLK_NS       (CLK_NS),
        .LEAD_NS      (LEAD_NS),
        .ACTIVE_NS    (ACTIVE_NS),
        .PRECHARGE_NS (PRECHARGE_NS),
        .CYCLE_NS     (CYCLE_NS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (ref_req),
        .gnt_i   (ref_gnt),
        .take_o  (take),
        .busy_o  (busy),
        .ras_n_o (ras_n),
        .cas_n_o (cas_n),
        .we_n_o  (we_n),
        .oe_n_o  (oe_n)
    );
endmodule

// File: tb/sim_cbr_refresh_gen.sv
`timescale 1ns/1ps
module sim_cbr_refresh_gen;
    localparam int N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0;
    logic ref_req, ref_urgent, busy, ras_n, cas_n, we_n, oe_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [4:0] sb_q[$];

    always #5 clk = ~clk;

    cbr_refresh_gen #(
        .CLK_NS       (10),
        .INTERVAL_NS  (N * 10),
        .MAX_PEND     (4),
        .URGENT_LIMIT (3)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_gnt    (ref_gnt),
        .ref_req    (ref_req),
        .ref_urgent (ref_urgent),
        .busy       (busy),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .oe_n       (oe_n)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cyc %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // item = {busy, ras_n, cas_n, we_n, oe_n}
    task automatic push_refresh();
        sb_q.push_back(5'b11111);
        sb_q.push_back(5'b11011);
        repeat (6) sb_q.push_back(5'b10011);
        repeat (4) sb_q.push_back(5'b11111);
        sb_q.push_back(5'b01111);
    endtask

    always @(negedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            logic [4:0] e;
            e = sb_q.pop_front();
            check("R3/R4/R7/R8 strobe pattern", {busy, ras_n, cas_n, we_n, oe_n}, e);
        end
    end

    task automatic wait_cyc(input int target);
        while (cyc != target) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 strobes in reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
        check("R1 flags in reset", {busy, ref_req, ref_urgent}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after reset", {busy, ref_req, ref_urgent}, 3'b000);

        // R7: grant with nothing pending
        ref_gnt = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R7 grant ignored when idle", {busy, ras_n, cas_n}, 3'b011);
        end
        ref_gnt = 1'b0;

        // R2: first request exactly N cycles after release
        wait_cyc(N - 1);
        check("R2 no request before interval", ref_req, 0);
        @(negedge clk);
        check("R2 request at interval", ref_req, 1);

        // R5: urgent after three intervals
        wait_cyc(3 * N - 1);
        check("R5 not urgent below limit", ref_urgent, 0);
        @(negedge clk);
        check("R5 urgent at limit", ref_urgent, 1);

        // R6: saturated backlog, then grant held high
        wait_cyc(7 * N + 2);
        check("R5 urgent while backlog held", ref_urgent, 1);
        #1;
        ref_gnt = 1'b1;
        sb_q.push_back(5'b01111);
        repeat (4) push_refresh();
        repeat (4) sb_q.push_back(5'b01111);
        while (sb_q.size() > 0) @(negedge clk);
        #3;
        check("R6 request drops after MAX_PEND refreshes", ref_req, 0);
        check("R6 urgent cleared", ref_urgent, 0);
        ref_gnt = 1'b0;

        // R2: next interval adds one obligation
        wait_cyc(8 * N - 1);
        check("R2 no request before next interval", ref_req, 0);
        @(negedge clk);
        check("R2 request at next interval", ref_req, 1);
        check("R4 we_n/oe_n idle", {we_n, oe_n}, 2'b11);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule